// File: doc/BRIEF.md
# Multi-Line Receive Character Silo

This block gathers characters from up to sixteen serial line receivers into one shared first-in first-out silo. Each receiver presents a one-cycle valid strobe with its character and its parity and framing error flags. The block tags the character with the number of the line it came from and stores it as a single entry. A host drains the silo through a small register port. Each read of the receive data register returns the oldest entry and removes it.

A receive interrupt tells the host that work is waiting. It fires either as soon as any character is held or, when the host has set a nonzero alarm level, once the fill count reaches that level. A level of 16 is the usual setting for bulk traffic. A master clear bit empties the silo and returns the control state to its reset values.

Top module: `mux_rx_silo`

## Requirements
- R1: A read at address 1 with entries held returns the oldest entry as bit 15 = 1, bits 14:12 = overrun, framing and parity flags, bits 11:8 = line number and bits 7:0 = character. The read removes that entry.
- R2: A read at address 1 with the silo empty returns 0x0000 and changes no state.
- R3: Entries come out in arrival order. Characters that arrive in the same cycle are stored lowest line number first.
- R4: The silo holds at most 64 entries. A character offered while no space is left is discarded, and the entries already stored are unchanged.
- R5: After one or more characters are discarded, bit 14 is set on the next entry that is stored, and only on that entry.
- R6: Address 2 holds a 7-bit alarm level that reads back and resets to 0. When the level is nonzero, the interrupt flag (address 0, bit 7) sets one cycle after the fill count is at or above the level.
- R7: When the alarm level is 0, the interrupt flag sets one cycle after any entry is held.
- R8: The output rx_irq is high exactly when the interrupt flag and the enable bit (address 0, bit 6, written by the host) are both set.
- R9: A write to address 0 with bits 11 and 7 both clear clears the interrupt flag. The flag then stays clear while its set condition is absent.
- R10: A write to address 0 with bit 11 set empties the silo and clears the flag, the enable bit, the alarm level and any pending overrun mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ln_valid | input | NUM_LINES | Per-line character strobe, one cycle |
| ln_char | input | NUM_LINES*8 | Per-line character, line i in bits 8i+7:8i |
| ln_perr | input | NUM_LINES | Per-line parity error flag |
| ln_ferr | input | NUM_LINES | Per-line framing error (break) flag |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of address 1 pops |
| bus_addr | input | 2 | Register address: 0 control, 1 data, 2 alarm |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The silo is driven with single-line strobes, with all sixteen lines at once, and with sparse random subsets of lines against random host reads. Single-line strobes confirm field placement. Full-width bursts show whether same-cycle ordering is by line number and where the silo stops accepting at capacity. The random mix overlaps pushes with pops, so it separates free-space accounting done before the pop from accounting done after it. The interrupt is checked every cycle against a level model, with the alarm set to zero, to a mid value and to a value that cannot be reached. This tells a per-character trigger apart from a threshold trigger and shows an off-by-one in when the flag sets.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   localparam int BUS_W     = 16;
   localparam int CHAR_W    = 8;
   localparam int LINE_W    = 4;
   localparam int ALARM_W   = 7;
   localparam int ENTRY_W   = 15;
   localparam int BIT_VALID = 15;
   localparam int BIT_OVR   = 14;
   localparam int BIT_CLR   = 11;
   localparam int BIT_FLAG  = 7;
   localparam int BIT_EN    = 6;

   typedef enum logic [1:0] {
      ADDR_CTRL  = 2'd0,
      ADDR_DATA  = 2'd1,
      ADDR_ALARM = 2'd2
   } reg_addr_e;
endpackage

// File: rtl/rxs_store.sv
module rxs_store #(
   parameter int LINES = 16,
   parameter int DEPTH = 64,
   parameter int W     = 15,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [LINES-1:0] push,
   input  logic [LINES*W-1:0] push_data,
   input  logic             pop,
   output logic [W-1:0]     head,
   output logic [CW-1:0]    count
);
   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("rxs_store: DEPTH must be a power of two");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    rank [LINES];
   logic [LINES-1:0] accept;
   logic [CW-1:0]    n_acc;
   logic             any_drop;
   logic             ovr_pend;
   logic             do_pop;

   always_comb begin
      n_acc    = '0;
      any_drop = 1'b0;
      for (int i = 0; i < LINES; i++) begin
         rank[i]   = n_acc;
         accept[i] = push[i] && ((int'(count) + int'(n_acc)) < DEPTH);
         if (accept[i]) n_acc = n_acc + CW'(1);
         if (push[i] && !accept[i]) any_drop = 1'b1;
      end
   end

   assign do_pop = pop && (count != '0);
   assign head   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      for (int i = 0; i < LINES; i++) begin
         if (accept[i] && !clr) begin
            mem[wr_ptr + rank[i][AW-1:0]] <= push_data[i*W +: W]
               | {(ovr_pend && rank[i] == '0), {(W-1){1'b0}}};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         ovr_pend <= 1'b0;
      end else if (clr) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count    <= '0;
         ovr_pend <= 1'b0;
      end else begin
         wr_ptr <= wr_ptr + n_acc[AW-1:0];
         rd_ptr <= rd_ptr + AW'(do_pop);
         count  <= count + n_acc - CW'(do_pop);
         if (any_drop)            ovr_pend <= 1'b1;
         else if (n_acc != '0)    ovr_pend <= 1'b0;
      end
   end

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= DEPTH);

   // R4
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(count) == DEPTH && !pop && !clr) |=> int'(count) == DEPTH);

   // R2
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && push == '0) |=> count == '0);

   // R5
   ovr_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_drop && !clr) |=> ovr_pend);
endmodule

// File: rtl/rxs_irq.sv
module rxs_irq #(
   parameter int CW      = 7,
   parameter int ALARM_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mclr,
   input  logic               flag_clr,
   input  logic [CW-1:0]      count,
   input  logic [ALARM_W-1:0] alarm,
   output logic               flag
);
   logic hit;

   assign hit = (alarm == '0) ? (count != '0) : (int'(count) >= int'(alarm));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag <= 1'b0;
      else if (mclr || flag_clr) flag <= 1'b0;
      else if (hit)              flag <= 1'b1;
   end

   // R6
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm != '0 && int'(count) >= int'(alarm) && !mclr && !flag_clr) |=> flag);

   // R9
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr |=> !flag);
endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
   import rxs_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int DEPTH     = 64,
   localparam int CW       = $clog2(DEPTH) + 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_LINES-1:0]        ln_valid,
   input  logic [NUM_LINES*CHAR_W-1:0] ln_char,
   input  logic [NUM_LINES-1:0]        ln_perr,
   input  logic [NUM_LINES-1:0]        ln_ferr,
   input  logic                        bus_wr,
   input  logic                        bus_rd,
   input  logic [1:0]                  bus_addr,
   input  logic [BUS_W-1:0]            bus_wdata,
   output logic [BUS_W-1:0]            bus_rdata,
   output logic                        rx_irq
);
   generate
      if (NUM_LINES > (1 << LINE_W) || NUM_LINES < 1) begin : g_bad_lines
         $error("mux_rx_silo: NUM_LINES must be 1..16");
      end
      if (DEPTH > (1 << ALARM_W) - 1) begin : g_bad_depth
         $error("mux_rx_silo: DEPTH exceeds alarm range");
      end
   endgenerate

   logic [NUM_LINES*ENTRY_W-1:0] entries;
   logic [ENTRY_W-1:0]           head;
   logic [CW-1:0]                count;
   logic [ALARM_W-1:0]           alarm_q;
   logic                         en_q, flag;
   logic                         ctrl_wr, mclr, flag_clr, pop;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_LINES; gi++) begin : g_pack
         assign entries[gi*ENTRY_W +: ENTRY_W] =
            {1'b0, ln_ferr[gi], ln_perr[gi], LINE_W'(gi), ln_char[gi*CHAR_W +: CHAR_W]};
      end
   endgenerate

   assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
   assign mclr     = ctrl_wr && bus_wdata[BIT_CLR];
   assign flag_clr = ctrl_wr && !bus_wdata[BIT_CLR] && !bus_wdata[BIT_FLAG];
   assign pop      = bus_rd && (bus_addr == ADDR_DATA);

   rxs_store #(.LINES(NUM_LINES), .DEPTH(DEPTH), .W(ENTRY_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (mclr),
      .push     (ln_valid),
      .push_data(entries),
      .pop      (pop),
      .head     (head),
      .count    (count)
   );

   rxs_irq #(.CW(CW), .ALARM_W(ALARM_W)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .mclr    (mclr),
      .flag_clr(flag_clr),
      .count   (count),
      .alarm   (alarm_q),
      .flag    (flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         alarm_q <= '0;
      end else if (mclr) begin
         en_q    <= 1'b0;
         alarm_q <= '0;
      end else if (bus_wr) begin
         if (bus_addr == ADDR_CTRL)  en_q    <= bus_wdata[BIT_EN];
         if (bus_addr == ADDR_ALARM) alarm_q <= bus_wdata[ALARM_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_CTRL: begin
            bus_rdata[BIT_FLAG] = flag;
            bus_rdata[BIT_EN]   = en_q;
         end
         ADDR_DATA: begin
            if (count != '0) bus_rdata = {1'b1, head};
         end
         ADDR_ALARM: bus_rdata[ALARM_W-1:0] = alarm_q;
         default: bus_rdata = '0;
      endcase
   end

   assign rx_irq = flag && en_q;

   // R10
   mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mclr |=> (count == '0 && !en_q && alarm_q == '0 && !flag));

   // R1
   pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count != '0 && !bus_wr && ln_valid == '0) |=> int'(count) == int'($past(count)) - 1);
endmodule

// File: tb/mux_rx_silo_tb.sv
module mux_rx_silo_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 16;
   localparam int DP = 64;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [NL-1:0] ln_valid = '0;
   logic [NL*8-1:0] ln_char = '0;
   logic [NL-1:0] ln_perr = '0, ln_ferr = '0;
   logic          bus_wr = 0, bus_rd = 0;
   logic [1:0]    bus_addr = 0;
   logic [15:0]   bus_wdata = 0;
   logic [15:0]   bus_rdata;
   logic          rx_irq;

   mux_rx_silo u_dut (
      .clk(clk), .rst_n(rst_n), .ln_valid(ln_valid), .ln_char(ln_char),
      .ln_perr(ln_perr), .ln_ferr(ln_ferr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_irq(rx_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0;
   int q[$];
   bit m_ovr = 0, m_flag = 0, m_en = 0;
   int m_alarm = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit m_cond();
      if (m_alarm == 0) return q.size() != 0;
      return q.size() >= m_alarm;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   endtask

   task automatic step(input logic [15:0] v, input bit rd, input string tag);
      logic [7:0] ch [NL];
      logic [NL-1:0] pe, fe;
      logic [15:0] exp;
      int sz0, n;
      bit first, drop;
      for (int i = 0; i < NL; i++) begin
         ch[i] = 8'($urandom);
         pe[i] = ($urandom % 4) == 0;
         fe[i] = ($urandom % 5) == 0;
         ln_char[i*8 +: 8] = ch[i];
      end
      ln_valid = v; ln_perr = pe; ln_ferr = fe;
      bus_rd = rd; bus_addr = 2'd1;
      #1;
      if (rd) begin
         exp = (q.size() != 0) ? {1'b1, 15'(q[0])} : 16'h0000;
         chk(bus_rdata == exp, tag, bus_rdata, exp);
      end
      sz0 = q.size();
      if (m_cond()) m_flag = 1;
      if (rd && sz0 > 0) void'(q.pop_front());
      n = 0; first = 1; drop = 0;
      for (int i = 0; i < NL; i++) begin
         if (v[i]) begin
            if (n < DP - sz0) begin
               q.push_back(int'({m_ovr && first, fe[i], pe[i], 4'(i), ch[i]}));
               first = 0; n++;
            end else drop = 1;
         end
      end
      if (drop) m_ovr = 1;
      else if (n > 0) m_ovr = 0;
      @(posedge clk); @(negedge clk);
      ln_valid = '0; bus_rd = 0;
      chk(rx_irq == (m_flag && m_en), tag, rx_irq, m_flag && m_en);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      if (a == 2'd0) begin
         if (d[11]) begin
            q.delete(); m_flag = 0; m_en = 0; m_alarm = 0; m_ovr = 0;
         end else begin
            if (!d[7]) m_flag = 0;
            else if (m_cond()) m_flag = 1;
            m_en = d[6];
         end
      end else begin
         if (m_cond()) m_flag = 1;
         if (a == 2'd2) m_alarm = int'(d[6:0]);
      end
      @(posedge clk); @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd_reg(input logic [1:0] a, input logic [15:0] exp, input string tag);
      bus_rd = 1; bus_addr = a;
      #1;
      chk(bus_rdata == exp, tag, bus_rdata, exp);
      if (m_cond()) m_flag = 1;
      if (a == 2'd1 && q.size() > 0) void'(q.pop_front());
      @(posedge clk); @(negedge clk);
      bus_rd = 0;
   endtask

   task automatic drain(input string tag);
      while (q.size() > 0) step('0, 1, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; fails++;
      $display("FAIL watchdog: actual=%h expected=%h", 1, 0);
      finish_run();
   end

   initial begin
      void'($urandom(32'h1f3a));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk(rx_irq == 0, "R8", rx_irq, 0);
      rd_reg(2'd0, 16'h0000, "R8");
      rd_reg(2'd2, 16'h0000, "R6");
      rd_reg(2'd1, 16'h0000, "R2");

      // R1 single line field placement
      step(16'h0020, 0, "R1");
      step('0, 1, "R1");
      step('0, 1, "R2");
      step('0, 1, "R2");

      // R3 same-cycle ordering
      step(16'b1010_0000_0001_0010, 0, "R3");
      step(16'h8001, 0, "R3");
      drain("R3");

      // R7 zero alarm level, per-character flag, R8 gating
      wr(2'd0, 16'h00C0);
      step(16'h0001, 0, "R7");
      step('0, 0, "R7");
      chk(rx_irq == 1, "R7", rx_irq, 1);
      rd_reg(2'd0, 16'h00C0, "R8");
      wr(2'd0, 16'h0080);
      chk(rx_irq == 0, "R8", rx_irq, 0);
      wr(2'd0, 16'h00C0);
      chk(rx_irq == 1, "R8", rx_irq, 1);
      drain("R7");
      // R9 clear
      wr(2'd0, 16'h0040);
      step('0, 0, "R9");
      rd_reg(2'd0, 16'h0040, "R9");
      chk(rx_irq == 0, "R9", rx_irq, 0);

      // R6 threshold
      wr(2'd2, 16'd5);
      rd_reg(2'd2, 16'd5, "R6");
      step(16'h000F, 0, "R6");
      step('0, 0, "R6");
      step('0, 0, "R6");
      chk(rx_irq == 0, "R6", rx_irq, 0);
      step(16'h0080, 0, "R6");
      step('0, 0, "R6");
      chk(rx_irq == 1, "R6", rx_irq, 1);
      drain("R6");
      wr(2'd0, 16'h0040);
      wr(2'd2, 16'd100);

      // R4 capacity, R5 overrun marking
      repeat (4) step(16'hFFFF, 0, "R4");
      step(16'hFFFF, 0, "R4");
      step(16'h0004, 0, "R4");
      drain("R4");
      step(16'h0200, 0, "R5");
      step(16'h0004, 0, "R5");
      step('0, 1, "R5");
      step('0, 1, "R5");
      repeat (3) step(16'hFFFF, 0, "R5");
      step(16'h00FF, 1, "R5");
      step(16'hFFFF, 1, "R5");
      drain("R5");

      // R10 master clear
      wr(2'd2, 16'd3);
      wr(2'd0, 16'h00C0);
      repeat (4) step(16'hFFFF, 0, "R10");
      step(16'h0001, 0, "R10");
      wr(2'd0, 16'h0800);
      chk(rx_irq == 0, "R10", rx_irq, 0);
      rd_reg(2'd0, 16'h0000, "R10");
      rd_reg(2'd2, 16'h0000, "R10");
      rd_reg(2'd1, 16'h0000, "R10");
      step(16'h0400, 0, "R10");
      step('0, 1, "R10");

      // random mix
      wr(2'd0, 16'h00C0);
      for (int k = 0; k < 4000; k++) begin
         logic [15:0] v;
         int dens, rp;
         dens = (k % 1000 < 300) ? 3 : 8;
         rp   = (k % 1000 < 300) ? 15 : 60;
         for (int i = 0; i < NL; i++) v[i] = ($urandom % dens) == 0;
         if ($urandom % 200 == 0) wr(2'd2, 16'($urandom % 80));
         else if ($urandom % 250 == 0) wr(2'd0, 16'h0040);
         else step(v, ($urandom % 100) < rp, "R3");
      end
      drain("R1");
      finish_run();
   end
endmodule